// File: doc/BRIEF.md
# Message Interrupt Identifier Arbiter

This block sits between a message buffer array and a processor. It holds one pending-interrupt bit for each message buffer and one status-interrupt flag. From these it keeps a registered identifier word that names the most urgent pending cause, and it drives one interrupt line to the processor.

Message buffers are numbered from 1 to `NUM_BUF`. Bit k-1 of every per-buffer vector belongs to buffer k. Identifier code k (k from 1 to `NUM_BUF`) names buffer k. Code 0x8000 names a status event, and code 0 means that nothing is pending.

The controller core reports each status-register update with a strobe and a class bit. The class bit is 1 for an error event and 0 for a status event. Each class has its own enable. The status flag clears when the processor reads the status register. A pending message bit clears only through that buffer's clear strobe. The interrupt line is gated by a global enable, but the identifier keeps tracking the pending state while the line is masked.

Top module: `msg_irq_arbiter`

## Requirements
- R1: After reset, `int_id_o`, `pend_o` and `irq_o` are all zero, and `int_id_o` is 0 whenever neither a message bit nor the status flag is pending.
- R2: While the status flag is set, `int_id_o` is 0x8000, whatever message bits are pending.
- R3: With the status flag clear and message bits pending, `int_id_o` is the number of the lowest-numbered pending buffer. Bit k-1 of `buf_set_i`, `buf_clr_i` and `pend_o` belongs to buffer k, and identifier code k names buffer k.
- R4: A pulse on `buf_clr_i` bit k-1, with no set strobe on that bit, clears buffer k's pending bit. The identifier then moves to the next pending buffer, or to 0 if none is left.
- R5: A `stat_rd_i` pulse clears the status flag. The identifier then falls back to the message priority of R3.
- R6: The status flag changes only on `stat_upd_i` or `stat_rd_i`. Changing `err_ie_i` or `stat_ie_i` alone neither raises nor clears it.
- R7: `stat_upd_i` raises the status flag only if `stat_err_i`=1 with `err_ie_i`=1, or `stat_err_i`=0 with `stat_ie_i`=1.
- R8: `irq_o` is 1 exactly when `int_id_o` is non-zero and `line_en_i` is 1. `int_id_o` and `pend_o` keep updating while `line_en_i` is 0.
- R9: If a set strobe and a clear strobe reach the same buffer in one cycle, the buffer ends up pending. If an enabled status update and a status read arrive in one cycle, the flag ends up set.
- R10: `pend_o` reflects a strobe at the first rising edge after it. `int_id_o` reflects the new pending state one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_set_i | input | NUM_BUF | Per-buffer set strobes (bit k-1 = buffer k) |
| buf_clr_i | input | NUM_BUF | Per-buffer clear strobes |
| stat_upd_i | input | 1 | Core updated the status register |
| stat_err_i | input | 1 | Class of the update: 1 error, 0 status |
| stat_rd_i | input | 1 | Processor read of the status register |
| line_en_i | input | 1 | Global interrupt line enable |
| err_ie_i | input | 1 | Enable for error-class status interrupts |
| stat_ie_i | input | 1 | Enable for status-class status interrupts |
| int_id_o | output | 16 | Identifier of the highest-priority cause |
| pend_o | output | NUM_BUF | Pending message bits |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
Same-cycle collisions are the hardest cases to reach: a set and a clear on one buffer, and a status update together with a status read. The driver places both strobes in one call, and the scoreboard checks the resulting pending state. Priority is checked at the extremes, with buffers 1 and 32 pending together and with the status flag raised over a full message vector. This shows both the top code and the fall-back after the read. Masking is checked by clearing the line enable while pending bits change, so the identifier must move while `irq_o` stays low.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
  localparam int unsigned ID_W = 16;
  localparam logic [ID_W-1:0] STAT_CODE = 16'h8000;
  localparam logic [ID_W-1:0] IDLE_CODE = '0;
endpackage

// File: rtl/msg_pend_bank.sv
module msg_pend_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q <= 1'b0;
      else if (set_i[k])  pend_q <= 1'b1;  // set wins over clear
      else if (clr_i[k])  pend_q <= 1'b0;
    end
    assign pend_o[k] = pend_q;

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> pend_o[k]);
    p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !pend_o[k]);
    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[k] && !set_i[k]) |=> $stable(pend_o[k]));
  end
endmodule

// File: rtl/msg_stat_flag.sv
module msg_stat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic err_i,
  input  logic rd_i,
  input  logic err_ie_i,
  input  logic stat_ie_i,
  output logic flag_o
);
  logic hit;
  logic flag_q;

  assign hit = upd_i & (err_i ? err_ie_i : stat_ie_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;  // update beats a same-cycle read
    else if (rd_i)  flag_q <= 1'b0;
  end
  assign flag_o = flag_q;

  p_only_strobes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !rd_i) |=> $stable(flag_o));
  p_err_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && err_i && !err_ie_i && !flag_o) |=> !flag_o);
  p_stat_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !err_i && !stat_ie_i && !flag_o) |=> !flag_o);
  p_rd_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !upd_i) |=> !flag_o);
  p_upd_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && err_i && err_ie_i) |=> flag_o);
endmodule

// File: rtl/msg_prio_enc.sv
module msg_prio_enc #(
  parameter int unsigned N = 32,
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] code_o
);
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

  // code = lowest set index + 1
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) code_o = W'(i + 1);
    end
  end
  assign any_o = |vec_i;

  logic [PW-1:0] pos_c;
  logic [N-1:0]  below_c;
  assign pos_c   = PW'(code_o - W'(1));
  assign below_c = (N'(1) << pos_c) - N'(1);

  p_lowest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (code_o != '0 && code_o <= W'(N) && vec_i[pos_c]
               && (vec_i & below_c) == '0));
  p_none_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_o |-> code_o == '0);
endmodule

// File: rtl/msg_irq_arbiter.sv
module msg_irq_arbiter
  import msg_irq_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BUF-1:0] buf_set_i,
  input  logic [NUM_BUF-1:0] buf_clr_i,
  input  logic               stat_upd_i,
  input  logic               stat_err_i,
  input  logic               stat_rd_i,
  input  logic               line_en_i,
  input  logic               err_ie_i,
  input  logic               stat_ie_i,
  output logic [ID_W-1:0]    int_id_o,
  output logic [NUM_BUF-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_BUF-1:0] pend_q;
  logic               stat_q;
  logic               msg_any;
  logic [ID_W-1:0]    msg_code;
  logic [ID_W-1:0]    id_d, id_q;

  msg_pend_bank #(.N(NUM_BUF)) i_bank (
    .clk_i, .rst_ni,
    .set_i  (buf_set_i),
    .clr_i  (buf_clr_i),
    .pend_o (pend_q)
  );

  msg_stat_flag i_stat (
    .clk_i, .rst_ni,
    .upd_i     (stat_upd_i),
    .err_i     (stat_err_i),
    .rd_i      (stat_rd_i),
    .err_ie_i  (err_ie_i),
    .stat_ie_i (stat_ie_i),
    .flag_o    (stat_q)
  );

  msg_prio_enc #(.N(NUM_BUF), .W(ID_W)) i_enc (
    .clk_i, .rst_ni,
    .vec_i  (pend_q),
    .any_o  (msg_any),
    .code_o (msg_code)
  );

  always_comb begin
    if (stat_q)       id_d = STAT_CODE;
    else if (msg_any) id_d = msg_code;
    else              id_d = IDLE_CODE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) id_q <= IDLE_CODE;
    else         id_q <= id_d;
  end

  assign int_id_o = id_q;
  assign pend_o   = pend_q;
  assign irq_o    = line_en_i & (id_q != IDLE_CODE);

  p_stat_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q |=> int_id_o == STAT_CODE);
  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_q && !(|pend_q)) |=> int_id_o == IDLE_CODE);
  p_msg_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_q && (|pend_q)) |=> (int_id_o != IDLE_CODE && int_id_o <= ID_W'(NUM_BUF)));
endmodule

// File: tb/test_msg_irq_arbiter.sv
module test_msg_irq_arbiter;
  localparam int NB = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] buf_set = '0, buf_clr = '0;
  logic          stat_upd = 0, stat_err = 0, stat_rd = 0;
  logic          line_en = 0, err_ie = 0, stat_ie = 0;
  logic [15:0]   int_id;
  logic [NB-1:0] pend;
  logic          irq;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  msg_irq_arbiter #(.NUM_BUF(NB)) i_msg_irq_arbiter (
    .clk_i(clk), .rst_ni(rst_n),
    .buf_set_i(buf_set), .buf_clr_i(buf_clr),
    .stat_upd_i(stat_upd), .stat_err_i(stat_err), .stat_rd_i(stat_rd),
    .line_en_i(line_en), .err_ie_i(err_ie), .stat_ie_i(stat_ie),
    .int_id_o(int_id), .pend_o(pend), .irq_o(irq)
  );

  // reference model
  logic [NB-1:0] m_pend = '0;
  logic          m_stat = 1'b0;

  string         q_tag[$];
  logic [15:0]   q_id[$];
  logic [NB-1:0] q_pend[$];
  logic          q_irq[$];

  function automatic logic [15:0] id_of(logic [NB-1:0] p, logic s);
    if (s) return 16'h8000;
    for (int k = 0; k < NB; k++) if (p[k]) return 16'(k + 1);
    return 16'h0;
  endfunction

  task automatic step(string tag, logic [NB-1:0] s, logic [NB-1:0] c,
                      logic upd, logic err, logic rd,
                      logic len, logic eie, logic sie);
    logic [15:0] eid;
    @(negedge clk);
    buf_set = s; buf_clr = c; stat_upd = upd; stat_err = err; stat_rd = rd;
    line_en = len; err_ie = eie; stat_ie = sie;
    eid = id_of(m_pend, m_stat);
    m_pend = s | (m_pend & ~c);
    m_stat = (upd & (err ? eie : sie)) | (m_stat & ~rd);
    q_tag.push_back(tag); q_id.push_back(eid);
    q_pend.push_back(m_pend); q_irq.push_back((eid != 0) & len);
  endtask

  task automatic idle(string tag, logic len, int n);
    for (int i = 0; i < n; i++) step(tag, '0, '0, 0, 0, 0, len, 1, 1);
  endtask

  function automatic logic [NB-1:0] b(int k);  // buffer k -> bit k-1
    return NB'(1) << (k - 1);
  endfunction

  // monitor
  initial begin
    forever begin
      @(posedge clk); #5;
      if (q_id.size() > 0) begin
        string t; logic [15:0] ei; logic [NB-1:0] ep; logic eq;
        t = q_tag.pop_front(); ei = q_id.pop_front();
        ep = q_pend.pop_front(); eq = q_irq.pop_front();
        checks++;
        if (int_id !== ei || pend !== ep || irq !== eq) begin
          errors++;
          $display("FAIL %s: id=%h pend=%h irq=%b expected id=%h pend=%h irq=%b",
                   t, int_id, pend, irq, ei, ep, eq);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #55;
    checks++;  // R1 reset state
    if (int_id !== 0 || pend !== 0 || irq !== 0) begin
      errors++;
      $display("FAIL R1 reset: id=%h pend=%h irq=%b expected 0 0 0", int_id, pend, irq);
    end
    @(negedge clk); rst_n = 1'b1;
    idle("R1 idle", 1, 2);
    // R3/R10: two buffers pending, lowest wins
    step("R10 set 5,9", b(5) | b(9), '0, 0, 0, 0, 1, 1, 1);
    idle("R3 lowest 5", 1, 2);
    step("R3 extremes", b(1) | b(32), '0, 0, 0, 0, 1, 1, 1);
    idle("R3 buffer 1", 1, 2);
    // R4: clear moves to next
    step("R4 clr 1", '0, b(1), 0, 0, 0, 1, 1, 1);
    idle("R4 next 5", 1, 2);
    step("R4 clr 5,9", '0, b(5) | b(9), 0, 0, 0, 1, 1, 1);
    idle("R4 next 32", 1, 2);
    // R9: set+clr same buffer
    step("R9 set+clr 3", b(3), b(3), 0, 0, 0, 1, 1, 1);
    idle("R9 pend 3", 1, 2);
    // R2: status outranks
    step("R2 err upd", '0, '0, 1, 1, 0, 1, 1, 1);
    idle("R2 top code", 1, 2);
    // R6: enables alone do nothing
    step("R6 en drop", '0, '0, 0, 0, 0, 1, 0, 0);
    idle("R6 hold", 1, 2);
    // R5: read clears
    step("R5 read", '0, '0, 0, 0, 1, 1, 1, 1);
    idle("R5 back to 3", 1, 2);
    // R7 gating
    step("R7 err masked", '0, '0, 1, 1, 0, 1, 0, 1);
    idle("R7 no flag err", 1, 2);
    step("R7 stat masked", '0, '0, 1, 0, 0, 1, 1, 0);
    idle("R7 no flag stat", 1, 2);
    step("R6 en raise", '0, '0, 0, 0, 0, 1, 1, 1);
    idle("R6 no flag", 1, 2);
    step("R7 stat upd", '0, '0, 1, 0, 0, 1, 0, 1);
    idle("R7 flag stat", 1, 2);
    // R9: update and read together
    step("R5 read2", '0, '0, 0, 0, 1, 1, 1, 1);
    step("R9 upd+rd", '0, '0, 1, 1, 1, 1, 1, 1);
    idle("R9 flag kept", 1, 2);
    step("R5 read3", '0, '0, 0, 0, 1, 1, 1, 1);
    // R8: masked line, id still moves
    step("R8 mask", b(2), '0, 0, 0, 0, 0, 1, 1);
    idle("R8 id moves masked", 0, 2);
    step("R8 clr masked", '0, b(2) | b(3), 0, 0, 0, 0, 1, 1);
    idle("R8 masked 32", 0, 2);
    idle("R8 unmask", 1, 1);
    // R2 over full vector
    step("R2 full", '1, '0, 1, 0, 0, 1, 1, 1);
    idle("R2 full top", 1, 2);
    step("R5 read4", '0, '0, 0, 0, 1, 1, 1, 1);
    idle("R3 full lowest", 1, 2);
    step("R1 clr all", '0, '1, 0, 0, 0, 1, 1, 1);
    idle("R1 empty", 1, 3);
    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule